// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block is the write-decode front end of a parallel NOR-style flash device. It watches the device select, write strobe, output strobe and a power-down reset input, together with the address and data buses. Bus writes are turned into commands, and the commands move the device between four read views: the memory array, the status byte, the identifier codes and a short query string. Program, block erase and block-lock operations run on an internal countdown timer. A small on-chip word array stands in for the cells. A busy/ready pin shows when an operation is in progress.

The write strobe is the AND of select low and write-enable low. A command takes the address and data present in the last cycle of that strobe, so whichever of the two enables goes inactive first closes the capture. Pulling the power-down reset low at any time stops the current operation. It then holds the pin low through a fixed recovery interval and brings the block back in array-read mode with a clean status byte. If an operation was cut short, a suspect-data flag is raised.

Top module: `flash_cmd_if`

## Requirements
- R1: When `rp_n` has been high for `REC_CYC`+1 cycles after a low period, the block is in array-read mode, status reads 80h and `sts` is 1.
- R2: Driving `rp_n` low while an operation is running aborts it: the array word or block keeps its old contents and `suspect` goes to 1. `suspect` is cleared by command 50h.
- R3: `sts` is 0 while `rp_n` is low and through the recovery interval. Commands written in that time are ignored.
- R4: A command captures the address and data of the last cycle in which `ce_n` and `we_n` were both low. Bus values after the first enable goes inactive are not used.
- R5: A write is accepted only while `ce_n` and `we_n` are both low. A `we_n` pulse with `ce_n` high has no effect. Commands have no address of their own.
- R6: Writing 20h and then D0h erases to FFFFh every word of the block that holds the D0h address. The block number is the top `BLOCK_W` address bits.
- R7: Writing 40h and then a data word programs the exact address of the data write. The new contents are the AND of the old word and the data.
- R8: Writing 60h and then 01h sets the lock bit of the block addressed by the 01h write. Writing 60h and then D0h at any address clears all lock bits.
- R9: In identifier mode (90h), `addr[0]` is ignored and `addr[2:1]` selects the code: 0 gives the maker code, 1 the device code, and 2 gives bit 0 = lock bit of the block in the top address bits. The upper byte always reads 00h.
- R10: While an operation runs, `sts` is 0, every read returns status and status bit 7 is 0. When it completes, bit 7 is 1 and `sts` returns to 1.
- R11: A confirm byte other than the expected one sets status bits 5 and 4 (30h), starts nothing, and leaves the block in status mode.
- R12: Programming a locked block sets status bits 4 and 1. Erasing a locked block sets bits 5 and 1. In both cases the array is not changed.
- R13: FFh selects array reads, 70h status reads and 98h query reads. Query word 0 reads 0051h, word 1 0052h and word 2 0059h. 50h clears status bits 6..0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rp_n | input | 1 | Active-low power-down reset; aborts operations |
| ce_n | input | 1 | Active-low device select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data / command byte in bits 7..0 |
| dout | output | 16 | Read data; 0 when not selected for reading |
| sts | output | 1 | 1 = ready, 0 = busy or in reset |
| suspect | output | 1 | An operation was aborted; contents may be partial |

## Verification
The assertions check the following on every cycle:
- `sts` stays low in the cycle after `rp_n` is low.
- A running operation always shows status bit 7 clear.
- An abort always raises `suspect`.
- No array write reaches a locked block.
- Each ended write strobe yields exactly one command, and a deselected bus yields none.
- Leaving recovery always lands in array mode with status 80h.

Only the bench scenarios can show the data results. These are the erased and programmed values (including the AND on a second program), the identifier and query codes, the error bits of a bad confirm or a locked target, and that commands issued during recovery or with the device deselected leave the observable state unchanged.

// File: rtl/flash_ci_pkg.sv
package flash_ci_pkg;
  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT, RM_QUERY} rmode_e;
  typedef enum logic [2:0] {ST_IDLE, ST_ERASE_SU, ST_PROG_SU, ST_LOCK_SU,
                            ST_BUSY, ST_RECOVER} fstate_e;
  typedef enum logic [1:0] {OP_PROG, OP_ERASE, OP_LOCK_SET, OP_LOCK_CLR} op_e;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
  localparam logic [7:0] CMD_READ_ID    = 8'h90;
  localparam logic [7:0] CMD_READ_QRY   = 8'h98;
  localparam logic [7:0] CMD_ERASE_SU   = 8'h20;
  localparam logic [7:0] CMD_PROG_SU    = 8'h40;
  localparam logic [7:0] CMD_LOCK_SU    = 8'h60;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_LOCK_SET   = 8'h01;

  localparam logic [7:0] SR_READY   = 8'h80;
  localparam logic [7:0] SR_ERS_ERR = 8'h20;
  localparam logic [7:0] SR_PRG_ERR = 8'h10;
  localparam logic [7:0] SR_LOCKED  = 8'h02;
endpackage

// File: rtl/fci_bus_capture.sv
module fci_bus_capture #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              cmd_stb,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  logic wr_act;
  logic wr_q;

  always_comb wr_act = !ce_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_act;
  end

  // capture register tracks the bus only while the strobe is active
  always_ff @(posedge clk) begin
    if (wr_act) begin
      cmd_addr <= addr;
      cmd_data <= din;
    end
  end

  // strobe ends on whichever enable rises first
  assign cmd_stb = wr_q && !wr_act;

  AST_ONE_CMD_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb); // R4
  AST_DESELECT_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !cmd_stb); // R5
endmodule

// File: rtl/fci_op_timer.sv
module fci_op_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  input  logic             abort,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    done   = busy && (cnt_q == CNT_W'(1)) && !abort;
    if (abort) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = load;
    end else if (busy) begin
      if (done) busy_d = 1'b0;
      else      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else begin
      busy  <= busy_d;
      cnt_q <= cnt_d;
    end
  end

  AST_TIMER_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> busy); // R10
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy); // R2
endmodule

// File: rtl/fci_array.sv
module fci_array #(
  parameter int ADDR_W  = 6,
  parameter int BLOCK_W = 2
) (
  input  logic               clk,
  input  logic               prog_en,
  input  logic               erase_en,
  input  logic [ADDR_W-1:0]  waddr,
  input  logic [15:0]        wdata,
  input  logic [BLOCK_W-1:0] eblk,
  input  logic [ADDR_W-1:0]  raddr,
  output logic [15:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WPB   = DEPTH >> BLOCK_W;

  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (erase_en && ((i / WPB) == int'(eblk)))
        mem[i] <= 16'hFFFF;
      else if (prog_en && (int'(waddr) == i))
        mem[i] <= mem[i] & wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_ci_pkg::*;
#(
  parameter int         ADDR_W    = 6,
  parameter int         BLOCK_W   = 2,
  parameter int         PROG_CYC  = 8,
  parameter int         ERASE_CYC = 20,
  parameter int         LOCK_CYC  = 6,
  parameter int         REC_CYC   = 5,
  parameter logic [7:0] MFR_CODE  = 8'hA7,
  parameter logic [7:0] DEV_CODE  = 8'h16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rp_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic              sts,
  output logic              suspect
);
  localparam int NBLK  = 1 << BLOCK_W;
  localparam int MAX_A = (PROG_CYC > LOCK_CYC) ? PROG_CYC : LOCK_CYC;
  localparam int MAX_C = (ERASE_CYC > MAX_A) ? ERASE_CYC : MAX_A;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam int REC_W = $clog2(REC_CYC + 1);

  fstate_e            state_q, state_d;
  rmode_e             mode_q, mode_d;
  op_e                op_q, op_d;
  logic [7:0]         status_q, status_d;
  logic [NBLK-1:0]    lock_q, lock_d;
  logic               suspect_d;
  logic [REC_W-1:0]   rec_q, rec_d;
  logic [ADDR_W-1:0]  op_addr_q, op_addr_d;
  logic [15:0]        op_data_q, op_data_d;

  logic               cmd_stb;
  logic [ADDR_W-1:0]  cmd_addr;
  logic [15:0]        cmd_data;
  logic [7:0]         cmd;
  logic [BLOCK_W-1:0] cmd_blk, op_blk, rd_blk;
  logic               tmr_start, tmr_busy, tmr_done;
  logic [CNT_W-1:0]   tmr_load;
  logic               arr_prog, arr_erase;
  logic [15:0]        arr_rdata;

  fci_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(16)) u_cap (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .cmd_stb(cmd_stb), .cmd_addr(cmd_addr), .cmd_data(cmd_data));

  fci_op_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .load(tmr_load), .abort(!rp_n),
    .busy(tmr_busy), .done(tmr_done));

  fci_array #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_arr (
    .clk(clk), .prog_en(arr_prog), .erase_en(arr_erase), .waddr(op_addr_q),
    .wdata(op_data_q), .eblk(op_blk), .raddr(addr), .rdata(arr_rdata));

  assign cmd     = cmd_data[7:0];
  assign cmd_blk = cmd_addr[ADDR_W-1 -: BLOCK_W];
  assign op_blk  = op_addr_q[ADDR_W-1 -: BLOCK_W];
  assign rd_blk  = addr[ADDR_W-1 -: BLOCK_W];

  assign arr_prog  = tmr_done && (op_q == OP_PROG);
  assign arr_erase = tmr_done && (op_q == OP_ERASE);

  // next-state logic
  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    op_d      = op_q;
    status_d  = status_q;
    lock_d    = lock_q;
    suspect_d = suspect;
    rec_d     = rec_q;
    op_addr_d = op_addr_q;
    op_data_d = op_data_q;
    tmr_start = 1'b0;
    tmr_load  = '0;
    if (!rp_n) begin
      if (state_q == ST_BUSY) suspect_d = 1'b1;
      state_d = ST_RECOVER;
      mode_d  = RM_STATUS;
      rec_d   = REC_W'(REC_CYC);
    end else begin
      unique case (state_q)
        ST_RECOVER: begin
          if (rec_q == '0) begin
            state_d  = ST_IDLE;
            mode_d   = RM_ARRAY;
            status_d = SR_READY;
          end else begin
            rec_d = rec_q - REC_W'(1);
          end
        end
        ST_IDLE: if (cmd_stb) begin
          unique case (cmd)
            CMD_READ_ARRAY: mode_d = RM_ARRAY;
            CMD_READ_STAT:  mode_d = RM_STATUS;
            CMD_READ_ID:    mode_d = RM_IDENT;
            CMD_READ_QRY:   mode_d = RM_QUERY;
            CMD_CLR_STAT: begin
              status_d  = status_q & SR_READY;
              suspect_d = 1'b0;
            end
            CMD_ERASE_SU: begin state_d = ST_ERASE_SU; mode_d = RM_STATUS; end
            CMD_PROG_SU:  begin state_d = ST_PROG_SU;  mode_d = RM_STATUS; end
            CMD_LOCK_SU:  begin state_d = ST_LOCK_SU;  mode_d = RM_STATUS; end
            default: ;
          endcase
        end
        ST_ERASE_SU: if (cmd_stb) begin
          state_d = ST_IDLE;
          if (cmd != CMD_CONFIRM)      status_d = status_q | SR_ERS_ERR | SR_PRG_ERR;
          else if (lock_q[cmd_blk])    status_d = status_q | SR_ERS_ERR | SR_LOCKED;
          else begin
            state_d = ST_BUSY; op_d = OP_ERASE; op_addr_d = cmd_addr;
            status_d = status_q & ~SR_READY;
            tmr_start = 1'b1; tmr_load = CNT_W'(ERASE_CYC);
          end
        end
        ST_PROG_SU: if (cmd_stb) begin
          state_d = ST_IDLE;
          if (lock_q[cmd_blk]) status_d = status_q | SR_PRG_ERR | SR_LOCKED;
          else begin
            state_d = ST_BUSY; op_d = OP_PROG;
            op_addr_d = cmd_addr; op_data_d = cmd_data;
            status_d = status_q & ~SR_READY;
            tmr_start = 1'b1; tmr_load = CNT_W'(PROG_CYC);
          end
        end
        ST_LOCK_SU: if (cmd_stb) begin
          state_d = ST_IDLE;
          if (cmd == CMD_LOCK_SET || cmd == CMD_CONFIRM) begin
            state_d   = ST_BUSY;
            op_d      = (cmd == CMD_LOCK_SET) ? OP_LOCK_SET : OP_LOCK_CLR;
            op_addr_d = cmd_addr;
            status_d  = status_q & ~SR_READY;
            tmr_start = 1'b1; tmr_load = CNT_W'(LOCK_CYC);
          end else begin
            status_d = status_q | SR_ERS_ERR | SR_PRG_ERR;
          end
        end
        ST_BUSY: if (tmr_done) begin
          state_d  = ST_IDLE;
          status_d = status_q | SR_READY;
          if (op_q == OP_LOCK_SET) lock_d[op_blk] = 1'b1;
          if (op_q == OP_LOCK_CLR) lock_d = '0;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= RM_ARRAY;
      op_q     <= OP_PROG;
      status_q <= SR_READY;
      lock_q   <= '0;
      suspect  <= 1'b0;
      rec_q    <= '0;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      op_q     <= op_d;
      status_q <= status_d;
      lock_q   <= lock_d;
      suspect  <= suspect_d;
      rec_q    <= rec_d;
    end
  end

  always_ff @(posedge clk) begin
    if (tmr_start) begin
      op_addr_q <= op_addr_d;
      op_data_q <= op_data_d;
    end
  end

  // read path
  always_comb begin
    dout = 16'h0000;
    if (!ce_n && !oe_n) begin
      if (state_q == ST_BUSY || mode_q == RM_STATUS) dout = {8'h00, status_q};
      else begin
        unique case (mode_q)
          RM_ARRAY: dout = arr_rdata;
          RM_IDENT: begin
            unique case (addr[2:1])
              2'd0:    dout = {8'h00, MFR_CODE};
              2'd1:    dout = {8'h00, DEV_CODE};
              2'd2:    dout = {15'h0000, lock_q[rd_blk]};
              default: dout = 16'h0000;
            endcase
          end
          RM_QUERY: begin
            unique case (addr[1:0])
              2'd0:    dout = 16'h0051;
              2'd1:    dout = 16'h0052;
              2'd2:    dout = 16'h0059;
              default: dout = 16'h0000;
            endcase
          end
          default: dout = {8'h00, status_q};
        endcase
      end
    end
  end

  assign sts = rp_n && (state_q != ST_BUSY) && (state_q != ST_RECOVER);

  AST_RP_HOLDS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |=> !sts); // R3
  AST_RECOVER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECOVER && state_d == ST_IDLE) |=>
      (status_q == 8'h80 && mode_q == RM_ARRAY)); // R1
  AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY && !rp_n) |=> suspect); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY) |-> !status_q[7]); // R10
  AST_LOCKED_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_prog || arr_erase) |-> !lock_q[op_blk]); // R12
endmodule

// File: tb/flash_cmd_if_bench.sv
module flash_cmd_if_bench;
  localparam int AW = 6;
  logic clk = 1'b0, rst_n = 1'b0, rp_n = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic sts, suspect;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];
  event        smp_ev;

  always #5 clk = ~clk;

  flash_cmd_if u_flash_cmd_if (.clk(clk), .rst_n(rst_n), .rp_n(rp_n), .ce_n(ce_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .sts(sts),
    .suspect(suspect));

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(smp_ev);
    if (exp_q.size() > 0) check(dout, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] e, input string tag);
    @(negedge clk); ce_n = 0; oe_n = 0; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1; -> smp_ev; #1;
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input bit ce_first);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a; din = d;
    @(negedge clk);
    if (ce_first) begin ce_n = 1; din = 16'hDEAD; addr = '0; end
    else we_n = 1;
    @(negedge clk); ce_n = 1; we_n = 1; din = '0;
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!sts && n < 300) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(16'(sts), 16'h1, "R1 ready after reset");
    check(16'(suspect), 16'h0, "R2 suspect clear after reset");
    wr(0, 16'h0070, 0); rd(0, 16'h0080, "R13 status after reset");

    // erase blocks 0 and 1
    wr(0, 16'h0020, 0); wr(3, 16'h00D0, 0);
    check(16'(sts), 16'h0, "R10 sts low while erasing");
    rd(9, 16'h0000, "R10 busy read returns status bit7=0");
    wait_ready();
    rd(0, 16'h0080, "R10 ready after erase");
    wr(16, 16'h0020, 0); wr(30, 16'h00D0, 0); wait_ready();
    wr(0, 16'h00FF, 0);
    rd(5, 16'hFFFF, "R6 block0 erased");
    rd(31, 16'hFFFF, "R6 block1 erased");

    // program and AND behaviour
    wr(5, 16'h0040, 0); wr(5, 16'h1234, 0); wait_ready();
    wr(0, 16'h00FF, 0);
    rd(5, 16'h1234, "R7 programmed word");
    rd(6, 16'hFFFF, "R7 neighbour untouched");
    wr(5, 16'h0040, 0); wr(5, 16'h0F0F, 0); wait_ready();
    wr(0, 16'h00FF, 0);
    rd(5, 16'h0204, "R7 second program ANDs");

    // capture closed by ce_n rising first
    wr(7, 16'h0040, 1); wr(7, 16'hA5A5, 1); wait_ready();
    wr(0, 16'h00FF, 0);
    rd(7, 16'hA5A5, "R4 capture on first deasserting enable");

    // deselected write ignored
    @(negedge clk); we_n = 0; din = 16'h0090; addr = 5;
    @(negedge clk); we_n = 1;
    rd(5, 16'h0204, "R5 write with ce_n high ignored");

    // identifier and query
    wr(0, 16'h0090, 0);
    rd(0, 16'h00A7, "R9 maker code");
    rd(1, 16'h00A7, "R9 addr0 ignored");
    rd(2, 16'h0016, "R9 device code");
    rd(20, 16'h0000, "R9 block1 unlocked");
    wr(0, 16'h0098, 0);
    rd(0, 16'h0051, "R13 query word0");
    rd(2, 16'h0059, "R13 query word2");

    // lock block 1
    wr(18, 16'h0060, 0); wr(18, 16'h0001, 0); wait_ready();
    wr(0, 16'h0090, 0);
    rd(20, 16'h0001, "R8 block1 locked");
    rd(4, 16'h0000, "R8 block0 still unlocked");
    wr(20, 16'h0040, 0); wr(20, 16'h0000, 0);
    check(16'(sts), 16'h1, "R12 locked program does not start");
    rd(0, 16'h0092, "R12 locked program status");
    wr(0, 16'h0050, 0); wr(17, 16'h0020, 0); wr(17, 16'h00D0, 0);
    rd(0, 16'h00A2, "R12 locked erase status");
    wr(0, 16'h00FF, 0);
    rd(20, 16'hFFFF, "R12 locked block unchanged");
    wr(0, 16'h0050, 0); wr(0, 16'h0070, 0);
    rd(0, 16'h0080, "R13 clear status");

    // bad confirm
    wr(0, 16'h0020, 0); wr(0, 16'h0055, 0);
    rd(0, 16'h00B0, "R11 bad confirm status mode");
    wr(0, 16'h0050, 0);

    // clear locks at unrelated address
    wr(9, 16'h0060, 0); wr(9, 16'h00D0, 0); wait_ready();
    wr(0, 16'h0090, 0);
    rd(20, 16'h0000, "R8 locks cleared");

    // abort program
    wr(8, 16'h0040, 0); wr(8, 16'h0000, 0);
    @(negedge clk); @(negedge clk); rp_n = 0;
    @(negedge clk);
    check(16'(sts), 16'h0, "R3 sts low in reset");
    @(negedge clk); rp_n = 1;
    @(negedge clk);
    check(16'(sts), 16'h0, "R3 sts low during recovery");
    wr(0, 16'h0090, 0);
    wait_ready();
    check(16'(suspect), 16'h1, "R2 abort sets suspect");
    rd(8, 16'hFFFF, "R2 aborted word unchanged / R3 cmd ignored / R1 array mode");
    wr(0, 16'h0070, 0);
    rd(0, 16'h0080, "R1 status after recovery");
    wr(0, 16'h0050, 0);
    @(negedge clk);
    check(16'(suspect), 16'h0, "R2 suspect cleared by 50h");

    repeat (5) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule